// File: doc/BRIEF.md
# Branch, Call and Return Sequencer

This block computes the next program counter and stack pointer for an 8-bit processor with a 16-bit address space. Once an instruction has been decoded, the core presents one request. The request carries the instruction class, a 3-bit condition or restart number, an unconditional flag, the four status flags (carry, zero, sign, parity), the current PC, the 16-bit operand target, the HL pair and the current SP. The block settles the outcome. It can jump, call, return, load the PC from HL or restart. Where the stack is involved, it moves the return address one byte at a time through a single-byte memory port.

Requests use a valid/ready handshake. The block raises `req_ready` only when it is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high, and all request fields are latched at that edge, so the core may change them afterwards. The memory port is also valid/ready. While `mem_valid` is high and `mem_ready` is low, the address, direction and write data stay frozen. Read data is taken from `mem_rdata` in the cycle of the handshake. Each accepted request ends with a one-cycle `done` pulse, and the result is on `new_pc` and `new_sp` during that pulse.

Top module: `npc_sequencer`

## Requirements
- R1: The condition field selects the test. 000 means Z=0, 001 means Z=1, 010 means CY=0, 011 means CY=1, 100 means P=0, 101 means P=1, 110 means S=0 and 111 means S=1. With `req_always` high the condition is ignored.
- R2: Class 000 (jump): when taken, `new_pc` equals `target`. SP is unchanged and there is no memory traffic.
- R3: When the condition fails, jump (000) and call (001) give PC+3 and return (010) gives PC+1. SP is unchanged and there is no memory traffic.
- R4: Class 001 (call), when taken, writes the high byte of PC+3 at SP-1 and then the low byte at SP-2. It ends with `new_sp`=SP-2 and `new_pc`=`target`. Addresses wrap modulo 2^16.
- R5: Class 010 (return), when taken, reads the low byte at SP and then the high byte at SP+1. It ends with `new_pc` equal to those two bytes and `new_sp`=SP+2, wrapping modulo 2^16.
- R6: Class 011 gives `new_pc`=`hl`, where H is the high byte and L the low byte. The condition and `req_always` are ignored, SP is unchanged and there is no memory traffic.
- R7: Class 100 (restart n, with n taken from the condition field) always pushes PC+1 in the same order as R4. It ends with `new_pc`=n*8 (0000h to 0038h) and `new_sp`=SP-2.
- R8: `req_ready` is high only while the block is idle, so it is low during memory traffic and during `done`. While `mem_valid` is high and `mem_ready` is low, `mem_addr`, `mem_write` and `mem_wdata` hold steady.
- R9: Every accepted request produces exactly one `done` pulse, one cycle long.
- R10: After reset `req_ready` is 1, and `done` and `mem_valid` are 0.
- R11: Class values 101 to 111 give `new_pc`=PC+1 with SP unchanged and no memory traffic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle and able to accept a request |
| req_class | input | 3 | 000 jump, 001 call, 010 return, 011 PC from HL, 100 restart |
| req_cond | input | 3 | Condition code, or the restart number for class 100 |
| req_always | input | 1 | Unconditional form |
| flag_cy | input | 1 | Carry flag |
| flag_z | input | 1 | Zero flag |
| flag_s | input | 1 | Sign flag |
| flag_p | input | 1 | Parity flag (1 = even) |
| cur_pc | input | 16 | Address of the current instruction |
| target | input | 16 | Operand address |
| hl | input | 16 | HL register pair |
| cur_sp | input | 16 | Current stack pointer |
| mem_valid | output | 1 | Memory access request |
| mem_ready | input | 1 | Memory accepts the access this cycle |
| mem_write | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 16 | Byte address |
| mem_wdata | output | 8 | Write byte |
| mem_rdata | input | 8 | Read byte, valid in the handshake cycle |
| done | output | 1 | One-cycle completion pulse |
| new_pc | output | 16 | Resulting PC, valid while `done` is high |
| new_sp | output | 16 | Resulting SP, valid while `done` is high |

## Verification
The hardest case to reach is a stack access that straddles the ends of the address space while the memory stalls in the middle of a two-byte transfer. In that case the byte order and the modulo-2^16 arithmetic both have to stay correct across held cycles. The stimulus places SP at 0001h for a call, so the push lands on 0000h and FFFFh. A return then starts from FFFFh and reads back the bytes that call left behind. Throughout the run the model memory withholds `mem_ready` at random. All eight conditions are tried against flag patterns that make each one both pass and fail.

// File: rtl/npc_pkg.sv
package npc_pkg;
  localparam int ADDR_BITS = 16;
  localparam int BYTE_BITS = 8;

  localparam logic [2:0] CLS_JUMP = 3'b000;
  localparam logic [2:0] CLS_CALL = 3'b001;
  localparam logic [2:0] CLS_RET  = 3'b010;
  localparam logic [2:0] CLS_HLPC = 3'b011;
  localparam logic [2:0] CLS_RST  = 3'b100;

  typedef enum logic [1:0] {ACT_FIN, ACT_PUSH, ACT_POP} act_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PUSH_HI, ST_PUSH_LO, ST_POP_LO, ST_POP_HI, ST_DONE
  } seq_state_e;
endpackage

// File: rtl/npc_cond_eval.sv
module npc_cond_eval (
  input  logic [2:0] code,
  input  logic       cy,
  input  logic       z,
  input  logic       s,
  input  logic       p,
  output logic       holds
);
  logic picked;

  always_comb begin
    unique case (code[2:1])
      2'b00:   picked = z;
      2'b01:   picked = cy;
      2'b10:   picked = p;
      default: picked = s;
    endcase
    // low bit of the code gives the flag value that satisfies the test
    holds = (picked == code[0]);
  end
endmodule

// File: rtl/npc_addr_calc.sv
module npc_addr_calc
  import npc_pkg::*;
#(
  parameter int AW        = ADDR_BITS,
  parameter int VEC_SHIFT = 3,
  parameter int LONG_LEN  = 3,
  parameter int SHORT_LEN = 1
) (
  input  logic [2:0]    cls,
  input  logic [2:0]    cond,
  input  logic          always_i,
  input  logic          cond_ok,
  input  logic [AW-1:0] cur_pc,
  input  logic [AW-1:0] target,
  input  logic [AW-1:0] hl,
  output act_e          act,
  output logic [AW-1:0] next_pc,
  output logic [AW-1:0] ret_addr
);
  localparam logic [AW-1:0] STEP_LONG  = AW'(LONG_LEN);
  localparam logic [AW-1:0] STEP_SHORT = AW'(SHORT_LEN);

  logic          taken;
  logic [AW-1:0] pc_long, pc_short, vector;

  assign taken    = always_i | cond_ok;
  assign pc_long  = cur_pc + STEP_LONG;
  assign pc_short = cur_pc + STEP_SHORT;
  assign vector   = AW'({cond, {VEC_SHIFT{1'b0}}});

  always_comb begin
    act      = ACT_FIN;
    next_pc  = pc_short;
    ret_addr = pc_long;
    unique case (cls)
      CLS_JUMP: next_pc = taken ? target : pc_long;
      CLS_CALL: begin
        next_pc = taken ? target : pc_long;
        act     = taken ? ACT_PUSH : ACT_FIN;
      end
      CLS_RET: begin
        next_pc = pc_short;
        act     = taken ? ACT_POP : ACT_FIN;
      end
      CLS_HLPC: next_pc = hl;
      CLS_RST: begin
        next_pc  = vector;
        ret_addr = pc_short;
        act      = ACT_PUSH;
      end
      default: next_pc = pc_short;
    endcase
  end
endmodule

// File: rtl/npc_seq_ctrl.sv
module npc_seq_ctrl
  import npc_pkg::*;
#(
  parameter int AW = ADDR_BITS,
  parameter int DW = BYTE_BITS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  act_e          act,
  input  logic [AW-1:0] next_pc,
  input  logic [AW-1:0] ret_addr,
  input  logic [AW-1:0] cur_sp,
  output logic          idle,
  output logic          mem_valid,
  input  logic          mem_ready,
  output logic          mem_write,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          done,
  output logic [AW-1:0] new_pc,
  output logic [AW-1:0] new_sp
);
  localparam logic [AW-1:0] ONE = AW'(1);
  localparam logic [AW-1:0] TWO = AW'(2);

  seq_state_e    st;
  logic [AW-1:0] pc_r, sp_r, ret_r;
  logic [DW-1:0] lo_r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      pc_r  <= '0;
      sp_r  <= '0;
      ret_r <= '0;
      lo_r  <= '0;
    end else begin
      unique case (st)
        ST_IDLE: if (start) begin
          pc_r  <= next_pc;
          sp_r  <= cur_sp;
          ret_r <= ret_addr;
          st    <= (act == ACT_PUSH) ? ST_PUSH_HI :
                   (act == ACT_POP)  ? ST_POP_LO  : ST_DONE;
        end
        ST_PUSH_HI: if (mem_ready) st <= ST_PUSH_LO;
        ST_PUSH_LO: if (mem_ready) begin
          sp_r <= sp_r - TWO;
          st   <= ST_DONE;
        end
        ST_POP_LO: if (mem_ready) begin
          lo_r <= mem_rdata;
          st   <= ST_POP_HI;
        end
        ST_POP_HI: if (mem_ready) begin
          pc_r <= {mem_rdata, lo_r};
          sp_r <= sp_r + TWO;
          st   <= ST_DONE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_valid = 1'b0;
    mem_write = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    unique case (st)
      ST_PUSH_HI: begin
        mem_valid = 1'b1;
        mem_write = 1'b1;
        mem_addr  = sp_r - ONE;
        mem_wdata = ret_r[AW-1 -: DW];
      end
      ST_PUSH_LO: begin
        mem_valid = 1'b1;
        mem_write = 1'b1;
        mem_addr  = sp_r - TWO;
        mem_wdata = ret_r[DW-1:0];
      end
      ST_POP_LO: begin
        mem_valid = 1'b1;
        mem_addr  = sp_r;
      end
      ST_POP_HI: begin
        mem_valid = 1'b1;
        mem_addr  = sp_r + ONE;
      end
      default: ;
    endcase
  end

  assign idle   = (st == ST_IDLE);
  assign done   = (st == ST_DONE);
  assign new_pc = pc_r;
  assign new_sp = sp_r;
endmodule

// File: rtl/npc_sequencer.sv
module npc_sequencer
  import npc_pkg::*;
#(
  parameter int AW = ADDR_BITS,
  parameter int DW = BYTE_BITS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [2:0]    req_class,
  input  logic [2:0]    req_cond,
  input  logic          req_always,
  input  logic          flag_cy,
  input  logic          flag_z,
  input  logic          flag_s,
  input  logic          flag_p,
  input  logic [AW-1:0] cur_pc,
  input  logic [AW-1:0] target,
  input  logic [AW-1:0] hl,
  input  logic [AW-1:0] cur_sp,
  output logic          mem_valid,
  input  logic          mem_ready,
  output logic          mem_write,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          done,
  output logic [AW-1:0] new_pc,
  output logic [AW-1:0] new_sp
);
  logic          cond_ok, idle, start;
  act_e          act;
  logic [AW-1:0] next_pc, ret_addr;

  assign req_ready = idle;
  assign start     = req_valid & idle;

  npc_cond_eval u_cond (
    .code(req_cond), .cy(flag_cy), .z(flag_z), .s(flag_s), .p(flag_p),
    .holds(cond_ok)
  );

  npc_addr_calc #(.AW(AW)) u_calc (
    .cls(req_class), .cond(req_cond), .always_i(req_always), .cond_ok(cond_ok),
    .cur_pc(cur_pc), .target(target), .hl(hl),
    .act(act), .next_pc(next_pc), .ret_addr(ret_addr)
  );

  npc_seq_ctrl #(.AW(AW), .DW(DW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .act(act),
    .next_pc(next_pc), .ret_addr(ret_addr), .cur_sp(cur_sp), .idle(idle),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_write(mem_write),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .done(done), .new_pc(new_pc), .new_sp(new_sp)
  );
endmodule

// File: rtl/npc_sequencer_chk.sv
module npc_sequencer_chk #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          mem_valid,
  input logic          mem_ready,
  input logic          mem_write,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata,
  input logic          done,
  input logic [AW-1:0] new_sp
);
  p_mem_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) &&
                                $stable(mem_write) && $stable(mem_wdata));

  p_busy_not_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid || done) |-> !req_ready);

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_valid && !done);

  p_push_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_write |->
      (mem_addr == new_sp - AW'(1)) || (mem_addr == new_sp - AW'(2)));

  p_push_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_ready && mem_write && (mem_addr == new_sp - AW'(1)) |=>
      mem_valid && mem_write && (mem_addr == $past(new_sp) - AW'(2)));

  p_pop_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_write |->
      (mem_addr == new_sp) || (mem_addr == new_sp + AW'(1)));
endmodule

bind npc_sequencer npc_sequencer_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .mem_valid(mem_valid),
  .mem_ready(mem_ready), .mem_write(mem_write), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .done(done), .new_sp(new_sp)
);

// File: tb/npc_sequencer_test.sv
module npc_sequencer_test;
  logic        clk = 0, rst_n = 0;
  logic        req_valid = 0, req_ready;
  logic [2:0]  req_class = 0, req_cond = 0;
  logic        req_always = 0, flag_cy = 0, flag_z = 0, flag_s = 0, flag_p = 0;
  logic [15:0] cur_pc = 0, target = 0, hl = 0, cur_sp = 0;
  logic        mem_valid, mem_ready = 1, mem_write, done;
  logic [15:0] mem_addr, new_pc, new_sp;
  logic [7:0]  mem_wdata, mem_rdata;

  always #5 clk = ~clk;

  npc_sequencer uut (.*);

  // behavioural stack memory, 256 bytes indexed by the low address byte
  logic [7:0] smem [0:255];
  assign mem_rdata = smem[mem_addr[7:0]];

  typedef struct {
    logic [15:0] pc, sp, wa0, wa1;
    logic [7:0]  wd0, wd1;
    int          nwr, nrd;
    string       tag;
  } exp_t;

  exp_t        expq[$];
  logic [15:0] wlog_a[$];
  logic [7:0]  wlog_d[$];
  int          rcnt = 0, viol = 0, total = 0, bad = 0;
  logic        held = 0;
  logic [15:0] h_a;
  logic [7:0]  h_d;
  logic        h_w;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  initial for (int i = 0; i < 256; i++) smem[i] = 8'(i) ^ 8'h5A;

  always @(negedge clk) mem_ready <= ($urandom_range(0, 3) != 0);

  always @(posedge clk) begin
    if (rst_n) begin
      if (held && !(mem_valid && mem_addr == h_a && mem_write == h_w &&
                    mem_wdata == h_d)) viol++;
      if (mem_valid && req_ready) viol++;
      held = mem_valid && !mem_ready;
      h_a = mem_addr; h_w = mem_write; h_d = mem_wdata;
      if (mem_valid && mem_ready) begin
        if (mem_write) begin
          smem[mem_addr[7:0]] = mem_wdata;
          wlog_a.push_back(mem_addr);
          wlog_d.push_back(mem_wdata);
        end else rcnt++;
      end
    end
  end

  function automatic bit cond_true(input logic [2:0] c, input logic cy, z, s, p);
    case (c)
      3'd0: return !z;
      3'd1: return z;
      3'd2: return !cy;
      3'd3: return cy;
      3'd4: return !p;
      3'd5: return p;
      3'd6: return !s;
      default: return s;
    endcase
  endfunction

  // driver: builds the expected result from the requirements, then offers the request
  task automatic issue(input logic [2:0] cls, input logic [2:0] cnd, input bit alw,
                       input logic [3:0] fl, input logic [15:0] pc, tgt, h, sp,
                       input string tag);
    exp_t e;
    logic [15:0] ra;
    bit taken;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    taken = alw || cond_true(cnd, fl[3], fl[2], fl[1], fl[0]);
    e.sp = sp; e.nwr = 0; e.nrd = 0; e.tag = tag; ra = 16'h0;
    e.wa0 = 0; e.wa1 = 0; e.wd0 = 0; e.wd1 = 0;
    case (cls)
      3'd0: e.pc = taken ? tgt : pc + 16'd3;
      3'd1: if (taken) begin ra = pc + 16'd3; e.pc = tgt; e.nwr = 2; end
            else e.pc = pc + 16'd3;
      3'd2: if (taken) begin
              e.pc = {smem[8'(sp + 16'd1)], smem[sp[7:0]]};
              e.sp = sp + 16'd2; e.nrd = 2;
            end else e.pc = pc + 16'd1;
      3'd3: e.pc = h;
      3'd4: begin ra = pc + 16'd1; e.pc = {10'd0, cnd, 3'd0}; e.nwr = 2; end
      default: e.pc = pc + 16'd1;
    endcase
    if (e.nwr == 2) begin
      e.wa0 = sp - 16'd1; e.wd0 = ra[15:8];
      e.wa1 = sp - 16'd2; e.wd1 = ra[7:0];
      e.sp  = sp - 16'd2;
    end
    expq.push_back(e);
    req_class = cls; req_cond = cnd; req_always = alw;
    {flag_cy, flag_z, flag_s, flag_p} = fl;
    cur_pc = pc; target = tgt; hl = h; cur_sp = sp; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    // scramble fields after acceptance: the latched request must not change
    cur_pc = ~pc; target = ~tgt; cur_sp = ~sp; flag_cy = ~flag_cy;
  endtask

  // monitor: pops the scoreboard at every done pulse
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      if (done) begin
        if (expq.size() == 0) chk(0, "R9", "done without request", 1, 0);
        else begin
          e = expq.pop_front();
          chk(new_pc == e.pc, e.tag, "new_pc", new_pc, e.pc);
          chk(new_sp == e.sp, e.tag, "new_sp", new_sp, e.sp);
          chk(wlog_a.size() == e.nwr, e.tag, "write count", wlog_a.size(), e.nwr);
          if (e.nwr == 2 && wlog_a.size() == 2) begin
            chk(wlog_a[0] == e.wa0, e.tag, "first write addr", wlog_a[0], e.wa0);
            chk(wlog_d[0] == e.wd0, e.tag, "first write data", wlog_d[0], e.wd0);
            chk(wlog_a[1] == e.wa1, e.tag, "second write addr", wlog_a[1], e.wa1);
            chk(wlog_d[1] == e.wd1, e.tag, "second write data", wlog_d[1], e.wd1);
          end
          chk(rcnt == e.nrd, e.tag, "read count", rcnt, e.nrd);
          chk(viol == 0, "R8", "handshake violations", viol, 0);
        end
        wlog_a.delete(); wlog_d.delete(); rcnt = 0; viol = 0;
        @(negedge clk);
        chk(!done, "R9", "done longer than one cycle", done, 0);
      end
    end
  end

  initial begin
    repeat (40000) @(posedge clk);
    chk(0, "watchdog", "run did not finish", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready == 1, "R10", "req_ready after reset", req_ready, 1);
    chk(done == 0, "R10", "done after reset", done, 0);
    chk(mem_valid == 0, "R10", "mem_valid after reset", mem_valid, 0);

    issue(3'd0, 3'd1, 1, 4'b0000, 16'h1000, 16'h2345, 16'h0, 16'h00F0, "R2 jump always");
    for (int c = 0; c < 8; c++) begin
      issue(3'd0, 3'(c), 0, 4'b0000, 16'h3000, 16'h4444, 16'h0, 16'h00E0, "R1 R3 jump cond");
      issue(3'd0, 3'(c), 0, 4'b1111, 16'h3100, 16'h5555, 16'h0, 16'h00E0, "R1 R3 jump cond");
      issue(3'd0, 3'(c), 0, 4'b1010, 16'h3200, 16'h6666, 16'h0, 16'h00E0, "R1 R3 jump cond");
      issue(3'd0, 3'(c), 0, 4'b0101, 16'h3300, 16'h7777, 16'h0, 16'h00E0, "R1 R3 jump cond");
    end
    issue(3'd1, 3'd3, 0, 4'b1000, 16'h1234, 16'hABCD, 16'h0, 16'h00F0, "R4 call carry taken");
    issue(3'd2, 3'd0, 0, 4'b0000, 16'hABCD, 16'h0, 16'h0, 16'h00EE, "R5 ret not-zero taken");
    issue(3'd1, 3'd1, 0, 4'b0000, 16'h2222, 16'h9999, 16'h0, 16'h00F0, "R3 call not taken");
    issue(3'd2, 3'd7, 0, 4'b0000, 16'h2222, 16'h0, 16'h0, 16'h00F0, "R3 ret not taken");
    issue(3'd1, 3'd0, 1, 4'b0100, 16'h4000, 16'h5000, 16'h0, 16'h0001, "R4 call wrap");
    issue(3'd2, 3'd0, 1, 4'b0100, 16'h5000, 16'h0, 16'h0, 16'hFFFF, "R5 ret wrap");
    issue(3'd3, 3'd2, 0, 4'b1111, 16'h0100, 16'h0, 16'hBEEF, 16'h0080, "R6 pc from hl");
    for (int n = 0; n < 8; n++)
      issue(3'd4, 3'(n), 0, 4'b0000, 16'h2000 + 16'(n), 16'h0, 16'h0, 16'h00C0, "R7 restart");
    issue(3'd2, 3'd1, 1, 4'b0000, 16'h0, 16'h0, 16'h0, 16'h00BE, "R5 ret after restart");
    issue(3'd5, 3'd0, 1, 4'b1111, 16'h7000, 16'h1111, 16'h2222, 16'h0090, "R11 reserved class");
    issue(3'd7, 3'd3, 1, 4'b0000, 16'hFFFF, 16'h1111, 16'h2222, 16'h0090, "R11 reserved class");

    while (expq.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule